// File: doc/BRIEF.md
# Lane delay calibration controller

This block sets the input delay taps of a multi-lane serial camera receiver: one clock lane and four data lanes. It aims to place sampling in the middle of the valid data window. The delay elements and the packet decoder sit outside the block. The block only issues load strobes and a tap value to the delay elements, and a reset request to the receiver and sensor. It takes back the receiver's error pulses and a pulse for each complete valid frame.

Software sets taps in one of two ways.

- **Direct write.** A write to the delay control word loads one tap value into every lane whose enable bit is set. It does not stop the data stream.
- **Automatic calibration.** The block first zeroes every lane. It then steps the chosen lane group through all 32 tap values. For each value it resets the receiver and sensor and runs a trial. The trial needs a programmable number of consecutive valid frames with no error pulse, and it fails on a silent timeout. At the end the block loads the centre of the longest passing run. If no tap passes, it reports failure and leaves all lanes at tap 0.

The block also keeps a sticky record of error pulses, which any clear write empties.

Top module: `lane_tap_tuner`

## Requirements
- R1: After reset, tap_load, tap_val, rx_rst, busy, done, cal_fail and err_sticky are all 0.
- R2: When idle, cfg_wr makes the next cycle show tap_load = cfg_wdata[28:24] for one cycle, together with tap_val = cfg_wdata[4:0]. Bit 28 selects the clock lane (tap_load[4]) and bits 27..24 select data lanes 3..0 (tap_load[3:0]). Every selected lane gets the same value.
- R3: cfg_wr is ignored while busy is 1; no load with its lane mask appears.
- R4: A direct write never raises rx_rst, so the stream continues.
- R5: rx_err[i] sets err_sticky[i], which then holds. Bit 0 is ECC, bit 1 is invalid packet, bit 2 is bad sequence and bit 3 is FIFO overflow. err_clr empties the register, but an error pulse in the same cycle is kept.
- R6: cal_start first loads tap 0 into all five lanes (mask 11111). It then loads taps 0 to 31 in ascending order into the swept group: data lanes (mask 01111) when cal_dir=0, or the clock lane (mask 10000) when cal_dir=1.
- R7: After each sweep load, rx_rst is high for exactly RST_CYCLES (default 4) consecutive cycles, giving 32 pulses per calibration.
- R8: A trial passes after cal_frames consecutive frame_ok pulses with no rx_err. Any rx_err bit during the trial fails it.
- R9: A trial fails when cal_timeout cycles pass with no frame_ok.
- R10: After tap 31, the final load writes to the swept group. The value is s + (L-1)/2 (rounded down), where the longest passing run starts at s and has length L; on a tie the earliest run is used.
- R11: If no tap passes, the final load writes 0 to all five lanes and cal_fail is 1 together with done.
- R12: busy is 1 from the cycle after cal_start until the final load. done rises the cycle after the final load, as busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the delay control word |
| cfg_wdata | input | 32 | Control word: lane enables [28:24], tap [4:0] |
| err_clr | input | 1 | Write to the sticky error register (clears it) |
| cal_start | input | 1 | Starts an automatic calibration |
| cal_dir | input | 1 | 0: sweep the data lanes, 1: sweep the clock lane |
| cal_frames | input | 4 | Consecutive valid frames a trial needs |
| cal_timeout | input | 16 | Cycles without a frame before a trial fails |
| rx_err | input | 4 | Receiver error pulses (ECC, packet, sequence, overflow) |
| frame_ok | input | 1 | Pulse per complete valid frame |
| tap_load | output | 5 | Per-lane load strobes (bit 4 clock lane) |
| tap_val | output | 5 | Tap value for the strobed lanes |
| rx_rst | output | 1 | Reset request to the receiver and sensor |
| err_sticky | output | 4 | Sticky error flags |
| busy | output | 1 | Calibration running |
| done | output | 1 | Calibration finished |
| cal_fail | output | 1 | No tap passed |

## Verification
Each result has a fixed latency, and the bench samples on the falling clock edge exactly there:

- A direct load, a sticky flag and the rise of busy all show one cycle after their input edge.
- The zeroing load shows in the first busy cycle.
- done shows one cycle after the final load.

Within a sweep, the bench's receiver model counts cycles from the falling edge of each rx_rst pulse. It places frames and errors at fixed offsets in that count, so each tap's verdict is known in advance. The expected final tap is computed arithmetically from the pass pattern. The sweeps cover all 32 single-passing-tap positions, edge runs, ties and the all-fail case.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_LOAD,
        ST_RESET,
        ST_TRIAL,
        ST_RECORD,
        ST_FINISH
    } cal_state_e;

    typedef enum logic [1:0] {
        VD_NONE,
        VD_PASS,
        VD_FAIL
    } verdict_e;
endpackage

// File: rtl/tt_err_sticky.sv
module tt_err_sticky #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_in,
    input  logic             clr,
    output logic [ERR_W-1:0] err_q
);
    logic [ERR_W-1:0] err_d;

    always_comb begin
        err_d = clr ? err_in : (err_q | err_in);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_q & $past(err_q)) == $past(err_q))); // R5
endmodule

// File: rtl/tt_trial_judge.sv
module tt_trial_judge
    import tt_pkg::*;
#(
    parameter int ERR_W = 4,
    parameter int FRM_W = 4,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             active,
    input  logic [ERR_W-1:0] rx_err,
    input  logic             frame_ok,
    input  logic [FRM_W-1:0] need,
    input  logic [TMO_W-1:0] tmo,
    output verdict_e         verdict
);
    typedef struct packed {
        verdict_e         vd;
        logic [FRM_W-1:0] fcnt;
        logic [TMO_W-1:0] timer;
    } jg_t;

    jg_t jg_d, jg_q;

    always_comb begin
        jg_d = jg_q;
        if (clr) begin
            jg_d.vd    = VD_NONE;
            jg_d.fcnt  = '0;
            jg_d.timer = '0;
        end else if (active && jg_q.vd == VD_NONE) begin
            if (|rx_err) begin
                jg_d.vd = VD_FAIL;
            end else if (frame_ok) begin
                jg_d.timer = '0;
                if ((FRM_W+1)'(jg_q.fcnt) + 1'b1 >= (FRM_W+1)'(need)) jg_d.vd = VD_PASS;
                else jg_d.fcnt = jg_q.fcnt + 1'b1;
            end else if ((TMO_W+1)'(jg_q.timer) + 1'b1 >= (TMO_W+1)'(tmo)) begin
                jg_d.vd = VD_FAIL;
            end else begin
                jg_d.timer = jg_q.timer + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) jg_q <= '{vd: VD_NONE, fcnt: '0, timer: '0};
        else        jg_q <= jg_d;
    end

    assign verdict = jg_q.vd;

    AST_VERDICT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (jg_q.vd != VD_NONE && !clr) |=> $stable(jg_q.vd)); // R8
    AST_ERR_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr && jg_q.vd == VD_NONE && |rx_err) |=> (jg_q.vd == VD_FAIL)); // R8
endmodule

// File: rtl/tt_run_track.sv
module tt_run_track #(
    parameter int TAP_W = 5,
    localparam int LEN_W = TAP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd,
    input  logic             pass,
    input  logic [TAP_W-1:0] idx,
    output logic [LEN_W-1:0] best_len,
    output logic [TAP_W-1:0] mid
);
    typedef struct packed {
        logic [TAP_W-1:0] cur_start;
        logic [LEN_W-1:0] cur_len;
        logic [TAP_W-1:0] best_start;
        logic [LEN_W-1:0] best_len;
    } run_t;

    run_t rn_d, rn_q;
    logic [TAP_W-1:0] start_n;
    logic [LEN_W-1:0] len_n;
    logic [LEN_W-1:0] half;

    always_comb begin
        rn_d    = rn_q;
        start_n = (rn_q.cur_len == '0) ? idx : rn_q.cur_start;
        len_n   = rn_q.cur_len + 1'b1;
        if (clr) begin
            rn_d = '0;
        end else if (upd) begin
            if (pass) begin
                rn_d.cur_start = start_n;
                rn_d.cur_len   = len_n;
                if (len_n > rn_q.best_len) begin
                    rn_d.best_start = start_n;
                    rn_d.best_len   = len_n;
                end
            end else begin
                rn_d.cur_len = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rn_q <= '0;
        else        rn_q <= rn_d;
    end

    assign half     = (rn_q.best_len - 1'b1) >> 1;
    assign best_len = rn_q.best_len;
    assign mid      = rn_q.best_start + TAP_W'(half);

    AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (rn_q.best_len >= $past(rn_q.best_len))); // R10
endmodule

// File: rtl/lane_tap_tuner.sv
module lane_tap_tuner
    import tt_pkg::*;
#(
    parameter int TAP_W      = 5,
    parameter int DATA_LANES = 4,
    parameter int ERR_W      = 4,
    parameter int FRM_W      = 4,
    parameter int TMO_W      = 16,
    parameter int RST_CYCLES = 4,
    parameter int EN_LSB     = 24,
    localparam int LANES     = DATA_LANES + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    input  logic             err_clr,
    input  logic             cal_start,
    input  logic             cal_dir,
    input  logic [FRM_W-1:0] cal_frames,
    input  logic [TMO_W-1:0] cal_timeout,
    input  logic [ERR_W-1:0] rx_err,
    input  logic             frame_ok,
    output logic [LANES-1:0] tap_load,
    output logic [TAP_W-1:0] tap_val,
    output logic             rx_rst,
    output logic [ERR_W-1:0] err_sticky,
    output logic             busy,
    output logic             done,
    output logic             cal_fail
);
    localparam int LEN_W = TAP_W + 1;
    localparam int RC_W  = $clog2(RST_CYCLES + 1);
    localparam logic [LANES-1:0] ALL_MASK  = {LANES{1'b1}};
    localparam logic [LANES-1:0] DATA_MASK = LANES'({DATA_LANES{1'b1}});
    localparam logic [LANES-1:0] CLK_MASK  = LANES'(1) << DATA_LANES;
    localparam logic [TAP_W-1:0] LAST_TAP  = {TAP_W{1'b1}};

    typedef struct packed {
        cal_state_e       st;
        logic [TAP_W-1:0] tap;
        logic [RC_W-1:0]  rcnt;
        logic             dir;
        logic             busy;
        logic             done;
        logic             fail;
        logic [LANES-1:0] man_load;
        logic [TAP_W-1:0] man_val;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    verdict_e         verdict;
    logic [LEN_W-1:0] best_len;
    logic [TAP_W-1:0] mid;
    logic [LANES-1:0] sweep_mask;
    logic             unused_cfg;

    assign unused_cfg = ^{cfg_wdata[31:EN_LSB+LANES], cfg_wdata[EN_LSB-1:TAP_W]};

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.man_load = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (cal_start) begin
                    ctl_d.st   = ST_ZERO;
                    ctl_d.dir  = cal_dir;
                    ctl_d.tap  = '0;
                    ctl_d.busy = 1'b1;
                    ctl_d.done = 1'b0;
                    ctl_d.fail = 1'b0;
                end else if (cfg_wr) begin
                    ctl_d.man_load = cfg_wdata[EN_LSB +: LANES];
                    ctl_d.man_val  = cfg_wdata[TAP_W-1:0];
                end
            end
            ST_ZERO: ctl_d.st = ST_LOAD;
            ST_LOAD: begin
                ctl_d.st   = ST_RESET;
                ctl_d.rcnt = '0;
            end
            ST_RESET: begin
                if (ctl_q.rcnt == RC_W'(RST_CYCLES - 1)) ctl_d.st = ST_TRIAL;
                else ctl_d.rcnt = ctl_q.rcnt + 1'b1;
            end
            ST_TRIAL: begin
                if (verdict != VD_NONE) ctl_d.st = ST_RECORD;
            end
            ST_RECORD: begin
                if (ctl_q.tap == LAST_TAP) begin
                    ctl_d.st = ST_FINISH;
                end else begin
                    ctl_d.tap = ctl_q.tap + 1'b1;
                    ctl_d.st  = ST_LOAD;
                end
            end
            ST_FINISH: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.fail = (best_len == '0);
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, tap: '0, rcnt: '0, dir: 1'b0, busy: 1'b0,
                       done: 1'b0, fail: 1'b0, man_load: '0, man_val: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sweep_mask = ctl_q.dir ? CLK_MASK : DATA_MASK;

    always_comb begin
        tap_load = ctl_q.man_load;
        tap_val  = ctl_q.man_val;
        case (ctl_q.st)
            ST_ZERO: begin
                tap_load = ALL_MASK;
                tap_val  = '0;
            end
            ST_LOAD: begin
                tap_load = sweep_mask;
                tap_val  = ctl_q.tap;
            end
            ST_FINISH: begin
                tap_load = (best_len == '0) ? ALL_MASK : sweep_mask;
                tap_val  = (best_len == '0) ? '0 : mid;
            end
            default: ;
        endcase
    end

    assign rx_rst   = (ctl_q.st == ST_RESET);
    assign busy     = ctl_q.busy;
    assign done     = ctl_q.done;
    assign cal_fail = ctl_q.fail;

    tt_err_sticky #(.ERR_W(ERR_W)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .err_in (rx_err),
        .clr    (err_clr),
        .err_q  (err_sticky)
    );

    tt_trial_judge #(.ERR_W(ERR_W), .FRM_W(FRM_W), .TMO_W(TMO_W)) u_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_q.st == ST_RESET),
        .active   (ctl_q.st == ST_TRIAL),
        .rx_err   (rx_err),
        .frame_ok (frame_ok),
        .need     (cal_frames),
        .tmo      (cal_timeout),
        .verdict  (verdict)
    );

    tt_run_track #(.TAP_W(TAP_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ctl_q.st == ST_ZERO),
        .upd      (ctl_q.st == ST_RECORD),
        .pass     (verdict == VD_PASS),
        .idx      (ctl_q.tap),
        .best_len (best_len),
        .mid      (mid)
    );

    AST_RST_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |-> ctl_q.busy); // R4
    AST_IGNORE_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && cfg_wr) |=> (ctl_q.man_load == '0)); // R3
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> !ctl_q.busy); // R12
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.fail |-> ctl_q.done); // R11
endmodule

// File: tb/lane_tap_tuner_test.sv
module lane_tap_tuner_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        err_clr = 1'b0;
    logic        cal_start = 1'b0;
    logic        cal_dir = 1'b0;
    logic [3:0]  cal_frames = 4'd2;
    logic [15:0] cal_timeout = 16'd20;
    logic [3:0]  t_err = '0;
    logic [3:0]  m_err = '0;
    logic        m_frame = 1'b0;
    logic [3:0]  rx_err;
    logic        frame_ok;
    logic [4:0]  tap_load;
    logic [4:0]  tap_val;
    logic        rx_rst, busy, done, cal_fail;
    logic [3:0]  err_sticky;

    assign rx_err   = m_err | t_err;
    assign frame_ok = m_frame;

    always #10 clk = ~clk;

    lane_tap_tuner uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .err_clr(err_clr), .cal_start(cal_start), .cal_dir(cal_dir),
        .cal_frames(cal_frames), .cal_timeout(cal_timeout), .rx_err(rx_err),
        .frame_ok(frame_ok), .tap_load(tap_load), .tap_val(tap_val),
        .rx_rst(rx_rst), .err_sticky(err_sticky), .busy(busy), .done(done),
        .cal_fail(cal_fail)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic wd = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) wd <= 1'b1;
    end

    // receiver model: 0 good, 1 frame then error, 2 silent, 3 two frames then silent, 4 early error
    int mode [32];
    int ev_n = 0;
    logic [4:0] ev_load [64];
    logic [4:0] ev_val [64];
    int rst_run = 0, rst_pulses = 0, rst_badlen = 0, stray = 0, tcyc = 0;
    logic armed = 1'b0, prev_busy = 1'b0;
    logic [4:0] cur_tap = '0;

    always @(negedge clk) begin
        m_frame = 1'b0;
        m_err   = '0;
        if (busy && !prev_busy) begin
            ev_n = 0; rst_pulses = 0; rst_badlen = 0; rst_run = 0; stray = 0;
        end
        prev_busy = busy;
        if (tap_load != '0) begin
            if (ev_n < 64) begin
                ev_load[ev_n] = tap_load;
                ev_val[ev_n]  = tap_val;
            end
            ev_n++;
            if (tap_load == 5'b10101) stray++;
            if (tap_load == (cal_dir ? 5'b10000 : 5'b01111)) cur_tap = tap_val;
        end
        if (rx_rst) begin
            rst_run++;
            armed = 1'b1;
            tcyc  = 0;
        end else begin
            if (rst_run > 0) begin
                rst_pulses++;
                if (rst_run != 4) rst_badlen++;
                rst_run = 0;
            end
            if (armed && busy) begin
                tcyc++;
                case (mode[cur_tap])
                    0: if (tcyc % 6 == 0) m_frame = 1'b1;
                    1: begin
                        if (tcyc == 6) m_frame = 1'b1;
                        if (tcyc == 9) m_err[cur_tap % 4] = 1'b1;
                    end
                    3: if (tcyc == 6 || tcyc == 12) m_frame = 1'b1;
                    4: if (tcyc == 2) m_err[cur_tap % 4] = 1'b1;
                    default: ;
                endcase
            end
            if (!busy) armed = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic all_fail();
        for (int t = 0; t < 32; t++) mode[t] = (t % 3 == 0) ? 1 : ((t % 3 == 1) ? 2 : 4);
    endtask

    task automatic set_range(input int lo, input int hi, input int m);
        for (int t = lo; t <= hi; t++) mode[t] = m;
    endtask

    task automatic manual_write(input logic [4:0] mask, input logic [4:0] val);
        @(negedge clk);
        cfg_wdata = {3'b000, mask, 19'd0, val};
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        chk(tap_load == mask, "R2", "manual lane mask", int'(tap_load), int'(mask));
        chk(tap_val == val, "R2", "manual tap value", int'(tap_val), int'(val));
        chk(rx_rst == 1'b0, "R4", "rx_rst during manual write", int'(rx_rst), 0);
        @(negedge clk);
        chk(tap_load == '0, "R2", "load strobe is one cycle", int'(tap_load), 0);
    endtask

    task automatic run_sweep(input bit dir, input int nfr, input bit inject);
        int best_s, best_l, cur_s, cur_l, exp_val, seq_bad;
        logic [4:0] exp_mask, swm;
        bit pass [32];
        cal_dir = dir;
        cal_frames = 4'(nfr);
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
        if (inject) begin
            repeat (40) @(negedge clk);
            cfg_wdata = 32'h1500_001f;
            cfg_wr = 1'b1;
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        while (!done && !wd) @(negedge clk);
        for (int t = 0; t < 32; t++) pass[t] = (mode[t] == 0) || (mode[t] == 3 && nfr <= 2);
        best_s = 0; best_l = 0; cur_s = 0; cur_l = 0;
        for (int t = 0; t < 32; t++) begin
            if (pass[t]) begin
                if (cur_l == 0) cur_s = t;
                cur_l++;
                if (cur_l > best_l) begin best_l = cur_l; best_s = cur_s; end
            end else cur_l = 0;
        end
        swm = dir ? 5'b10000 : 5'b01111;
        exp_mask = (best_l == 0) ? 5'b11111 : swm;
        exp_val  = (best_l == 0) ? 0 : best_s + (best_l - 1) / 2;
        chk(ev_n == 34, "R6", "load events per calibration", ev_n, 34);
        chk(ev_load[0] == 5'b11111 && ev_val[0] == 5'd0, "R6", "initial zero load mask", int'(ev_load[0]), 31);
        seq_bad = 0;
        for (int i = 1; i <= 32; i++)
            if (ev_load[i] != swm || int'(ev_val[i]) != i - 1) seq_bad++;
        chk(seq_bad == 0, "R6", "ascending sweep loads wrong", seq_bad, 0);
        chk(rst_pulses == 32 && rst_badlen == 0, "R7", "reset pulses of 4 cycles", rst_pulses * 100 + rst_badlen, 3200);
        if (best_l == 0) begin
            chk(ev_load[33] == exp_mask && ev_val[33] == 5'd0, "R11", "zero load on failure", int'(ev_load[33]), 31);
            chk(cal_fail == 1'b1, "R11", "cal_fail flag", int'(cal_fail), 1);
        end else begin
            chk(ev_load[33] == exp_mask, "R10", "final lane mask", int'(ev_load[33]), int'(exp_mask));
            chk(int'(ev_val[33]) == exp_val, "R10", "final centre tap (R8 R9 verdicts)", int'(ev_val[33]), exp_val);
            chk(cal_fail == 1'b0, "R11", "cal_fail clear on success", int'(cal_fail), 0);
        end
        chk(done == 1'b1 && busy == 1'b0, "R12", "done high busy low", int'({done, busy}), 2);
        if (inject) chk(stray == 0, "R3", "write during sweep produced load", stray, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tap_load == '0 && tap_val == '0, "R1", "tap outputs at reset", int'({tap_load, tap_val}), 0);
        chk(rx_rst == 1'b0 && busy == 1'b0, "R1", "rx_rst/busy at reset", int'({rx_rst, busy}), 0);
        chk(done == 1'b0 && cal_fail == 1'b0 && err_sticky == '0, "R1", "status at reset",
            int'({done, cal_fail, err_sticky}), 0);

        for (int m = 0; m < 32; m++) manual_write(5'(m), 5'((m * 7 + 3) % 32));

        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            t_err = 4'(1 << i);
            @(negedge clk);
            t_err = '0;
            chk(err_sticky == 4'((2 << i) - 1), "R5", "sticky accumulation", int'(err_sticky), (2 << i) - 1);
        end
        @(negedge clk);
        chk(err_sticky == 4'hf, "R5", "sticky holds", int'(err_sticky), 15);
        err_clr = 1'b1;
        t_err = 4'b0100;
        @(negedge clk);
        err_clr = 1'b0;
        t_err = '0;
        chk(err_sticky == 4'b0100, "R5", "clear keeps same-cycle error", int'(err_sticky), 4);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(err_sticky == '0, "R5", "clear empties", int'(err_sticky), 0);

        set_range(0, 31, 0);
        run_sweep(1'b0, 2, 1'b0);
        all_fail();
        run_sweep(1'b1, 2, 1'b0);
        all_fail(); set_range(0, 4, 0); set_range(20, 31, 0);
        run_sweep(1'b0, 2, 1'b1);
        all_fail(); set_range(3, 8, 0); set_range(12, 17, 0);
        run_sweep(1'b1, 2, 1'b0);
        all_fail(); set_range(25, 31, 0);
        run_sweep(1'b0, 2, 1'b0);
        all_fail(); set_range(10, 19, 3);
        run_sweep(1'b0, 2, 1'b0);
        run_sweep(1'b1, 3, 1'b0);
        all_fail(); set_range(0, 9, 0); set_range(14, 23, 0);
        run_sweep(1'b0, 3, 1'b0);
        for (int k = 0; k < 32; k++) begin
            all_fail();
            mode[k] = 0;
            run_sweep(1'(k % 2), 2, 1'b0);
        end

        manual_write(5'b10001, 5'd9);

        if (wd) begin
            total++;
            bad++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule